// File: doc/BRIEF.md
# Folded Global Path History

This block holds a long speculative global history of branch behaviour and keeps, for every tagged predictor table, compressed copies of that history. It also hashes a lookup PC with those copies into a table index and a partial tag. A branch event presents the branch PC, its target, a conditional flag and the taken bit. The block turns the event into a ten-bit path signature and shifts the signature into a circular bit buffer one bit per clock. On each of those clocks it updates the folded registers of every table.

Each table has a history length and three folded registers. The index fold is as wide as the log table size. The first tag fold is as wide as the tag, and the second is one bit narrower. Folding is cyclic. Each new bit enters at the bottom. The bit that leaves the table's history window is cancelled at a position derived from the history length. The bit that overflows the top wraps back into bit 0. While a signature is being shifted in, `ready` is low and the lookup outputs are not valid.

Top module: `fhist_top`

## Requirements
- R1: After reset `ready` is 1, the buffer, pointer and all folded registers are zero, so each table's index equals (PC xor (PC >> shift)) masked to the index width and each tag equals the PC masked to the tag width.
- R2: An event is accepted on a clock edge where `ev_valid` and `ready` are both 1. `ready` is then 0 for exactly ten cycles and returns to 1 after the tenth history bit has been inserted.
- R3: `ev_valid` asserted while `ready` is 0 is ignored, and the folded state reflects only accepted events.
- R4: For a non-conditional event (`ev_cond`=0) the ten inserted bits are bits 0..9 of target xor (target >> 3) xor PC, bit 0 first.
- R5: For a conditional event (`ev_cond`=1) the first inserted bit is `ev_taken` and the remaining nine are 0.
- R6: The buffer has DEPTH (4096) one-bit entries. The pointer starts at 0, is decremented before each write and wraps modulo DEPTH. A table's departing bit is read HLEN entries above the write position.
- R7: Each fold update shifts the register left by one and inserts the new bit at bit 0. It XORs the departing bit in at position (HLEN mod width), then XORs the old top bit into bit 0, keeping the width.
- R8: Table t (numbered from 1) has index (PC xor (PC >> (|LOGSZ - t| + 1)) xor index fold), masked to LOGSZ bits and zero-extended to OW.
- R9: Table t has tag (PC xor wide tag fold xor (narrow tag fold << 1)), masked to TAGW bits and zero-extended to OW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Branch event present |
| ev_pc | input | PCW | Branch PC of the event |
| ev_target | input | TW | Branch target of the event |
| ev_cond | input | 1 | Event is a conditional branch |
| ev_taken | input | 1 | Taken outcome of a conditional event |
| ready | output | 1 | Idle; event accepted and lookup outputs valid |
| lk_pc | input | PCW | PC to hash for lookup |
| lk_idx | output | NTAB x OW | Per-table index |
| lk_tag | output | NTAB x OW | Per-table partial tag |

## Verification
The bench builds four tables with history lengths 10, 27, 119 and 640, index widths 9, 9, 12 and 11, and tag widths 9, 9, 13 and 15. With these values the departing-bit position takes the top bit (119 mod 12), a middle bit, and position 0, where it lands on the same bit as the wrap-around feedback (27 mod 9). The longest window spans hundreds of entries. Over 450 random events, more than 4096 bits are inserted, so the pointer wraps while windows that straddle the wrap point are still being read.

// File: rtl/fhist_pkg.sv
package fhist_pkg;
   localparam int SIG_BITS = 10;
   localparam int CNT_W    = 4;

   function automatic int abs_diff(input int a, input int b);
      return (a > b) ? (a - b) : (b - a);
   endfunction
endpackage

// File: rtl/fhist_sig.sv
module fhist_sig #(
   parameter int PCW = 32,
   parameter int TW  = 32
) (
   input  logic [PCW-1:0]                 pc,
   input  logic [TW-1:0]                  target,
   input  logic                           cond,
   input  logic                           taken,
   output logic [fhist_pkg::SIG_BITS-1:0] sig
);
   localparam int SB = fhist_pkg::SIG_BITS;
   logic [SB-1:0] path_mix;

   generate
      if (TW >= SB + 3) begin : g_wide
         assign path_mix = SB'(target ^ (target >> 3)) ^ SB'(pc);
      end else begin : g_narrow
         assign path_mix = SB'({{SB{1'b0}}, target} ^ ({{SB{1'b0}}, target} >> 3)) ^ SB'(pc);
      end
   endgenerate

   assign sig = cond ? {{(SB-1){1'b0}}, taken} : path_mix;
endmodule

// File: rtl/fhist_fold.sv
module fhist_fold #(
   parameter int W    = 9,
   parameter int HLEN = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         step,
   input  logic         new_bit,
   input  logic         old_bit,
   output logic [W-1:0] fold
);
   localparam int OUTPT = HLEN % W;
   logic [W-1:0] nxt;

   always_comb begin
      nxt        = {fold[W-2:0], new_bit};
      nxt[OUTPT] = nxt[OUTPT] ^ old_bit;
      nxt[0]     = nxt[0] ^ fold[W-1];
   end

   always_ff @(posedge clk) begin
      if (rst)       fold <= '0;
      else if (step) fold <= nxt;
   end
endmodule

// File: rtl/fhist_hash.sv
module fhist_hash #(
   parameter int PCW = 32,
   parameter int IW  = 9,
   parameter int TGW = 9,
   parameter int SH  = 9,
   parameter int OW  = 16
) (
   input  logic [PCW-1:0] pc,
   input  logic [IW-1:0]  fi,
   input  logic [TGW-1:0] ft0,
   input  logic [TGW-2:0] ft1,
   output logic [OW-1:0]  idx,
   output logic [OW-1:0]  tag
);
   logic [IW-1:0]  idx_w;
   logic [TGW-1:0] tag_w;

   assign idx_w = IW'(pc ^ (pc >> SH)) ^ fi;
   assign tag_w = TGW'(pc) ^ ft0 ^ {ft1, 1'b0};

   generate
      if (OW > IW) begin : g_iext
         assign idx = {{(OW-IW){1'b0}}, idx_w};
      end else begin : g_ieq
         assign idx = idx_w;
      end
      if (OW > TGW) begin : g_text
         assign tag = {{(OW-TGW){1'b0}}, tag_w};
      end else begin : g_teq
         assign tag = tag_w;
      end
   endgenerate
endmodule

// File: rtl/fhist_top.sv
module fhist_top #(
   parameter int NTAB        = 4,
   parameter int DEPTH       = 4096,
   parameter int PCW         = 32,
   parameter int TW          = 32,
   parameter int OW          = 16,
   parameter int HLEN  [NTAB] = '{10, 27, 119, 640},
   parameter int LOGSZ [NTAB] = '{9, 9, 12, 11},
   parameter int TAGW  [NTAB] = '{9, 9, 13, 15}
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    ev_valid,
   input  logic [PCW-1:0]          ev_pc,
   input  logic [TW-1:0]           ev_target,
   input  logic                    ev_cond,
   input  logic                    ev_taken,
   output logic                    ready,
   input  logic [PCW-1:0]          lk_pc,
   output logic [NTAB-1:0][OW-1:0] lk_idx,
   output logic [NTAB-1:0][OW-1:0] lk_tag
);
   localparam int AW = $clog2(DEPTH);
   localparam int SB = fhist_pkg::SIG_BITS;
   localparam int CW = fhist_pkg::CNT_W;

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (PCW < SB) begin : g_bad_pcw
      $error("PCW must cover the signature");
   end
   for (genvar c = 0; c < NTAB; c++) begin : g_pchk
      if (HLEN[c] < 1 || HLEN[c] >= DEPTH) begin : g_bad_h
         $error("history length out of range");
      end
      if (LOGSZ[c] < 2 || LOGSZ[c] > OW || LOGSZ[c] > PCW) begin : g_bad_i
         $error("index width out of range");
      end
      if (TAGW[c] < 3 || TAGW[c] > OW || TAGW[c] > PCW) begin : g_bad_t
         $error("tag width out of range");
      end
   end

   logic [DEPTH-1:0] hbuf;
   logic [AW-1:0]    ptr;
   logic [AW-1:0]    wr_ptr;
   logic [CW-1:0]    cnt;
   logic [SB-1:0]    sig;
   logic [SB-1:0]    ev_sig;
   logic             step;

   assign step   = (cnt != '0);
   assign ready  = ~step;
   assign wr_ptr = ptr - 1'b1;

   fhist_sig #(.PCW(PCW), .TW(TW)) u_sig (
      .pc(ev_pc), .target(ev_target), .cond(ev_cond), .taken(ev_taken), .sig(ev_sig)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         hbuf <= '0;
         ptr  <= '0;
         cnt  <= '0;
         sig  <= '0;
      end else if (step) begin
         hbuf[wr_ptr] <= sig[0];
         ptr          <= wr_ptr;
         sig          <= sig >> 1;
         cnt          <= cnt - 1'b1;
      end else if (ev_valid) begin
         sig <= ev_sig;
         cnt <= CW'(SB);
      end
   end

   for (genvar t = 0; t < NTAB; t++) begin : g_tab
      localparam int IW  = LOGSZ[t];
      localparam int TGW = TAGW[t];
      localparam int SH  = fhist_pkg::abs_diff(LOGSZ[t], t + 1) + 1;
      logic           old_bit;
      logic [IW-1:0]  fi;
      logic [TGW-1:0] ft0;
      logic [TGW-2:0] ft1;

      assign old_bit = hbuf[wr_ptr + AW'(HLEN[t])];

      fhist_fold #(.W(IW), .HLEN(HLEN[t])) u_fi (
         .clk(clk), .rst(rst), .step(step), .new_bit(sig[0]), .old_bit(old_bit), .fold(fi));
      fhist_fold #(.W(TGW), .HLEN(HLEN[t])) u_ft0 (
         .clk(clk), .rst(rst), .step(step), .new_bit(sig[0]), .old_bit(old_bit), .fold(ft0));
      fhist_fold #(.W(TGW-1), .HLEN(HLEN[t])) u_ft1 (
         .clk(clk), .rst(rst), .step(step), .new_bit(sig[0]), .old_bit(old_bit), .fold(ft1));

      fhist_hash #(.PCW(PCW), .IW(IW), .TGW(TGW), .SH(SH), .OW(OW)) u_hash (
         .pc(lk_pc), .fi(fi), .ft0(ft0), .ft1(ft1), .idx(lk_idx[t]), .tag(lk_tag[t]));
   end
endmodule

// File: rtl/fhist_chk.sv
module fhist_chk #(
   parameter int NTAB = 4,
   parameter int OW   = 16,
   parameter int AW   = 12,
   parameter int PCW  = 32
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    ev_valid,
   input logic                    ready,
   input logic [AW-1:0]           ptr,
   input logic [PCW-1:0]          lk_pc,
   input logic [NTAB-1:0][OW-1:0] lk_idx,
   input logic [NTAB-1:0][OW-1:0] lk_tag
);
   p_accept_drop_r2: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ready) |=> !ready);

   p_busy_ten_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(ready) |-> $past(!ready, 10));

   p_ptr_step_r6: assert property (@(posedge clk) disable iff (rst)
      !ready |=> (ptr == $past(ptr) - 1'b1));

   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (rst)
      ready |=> (ptr == $past(ptr)));

   p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
      (ready && !ev_valid) ##1 (ready && $stable(lk_pc)) |-> ($stable(lk_idx) && $stable(lk_tag)));
endmodule

bind fhist_top fhist_chk #(.NTAB(NTAB), .OW(OW), .AW(AW), .PCW(PCW)) u_chk (
   .clk(clk), .rst(rst), .ev_valid(ev_valid), .ready(ready), .ptr(ptr),
   .lk_pc(lk_pc), .lk_idx(lk_idx), .lk_tag(lk_tag));

// File: tb/tb_fhist_top.sv
module tb_fhist_top;
   localparam int NTAB = 4;
   localparam int DEPTH = 4096;
   localparam int OW = 16;
   localparam int HL [NTAB] = '{10, 27, 119, 640};
   localparam int LS [NTAB] = '{9, 9, 12, 11};
   localparam int TG [NTAB] = '{9, 9, 13, 15};

   logic clk = 0;
   logic rst = 1;
   logic ev_valid = 0, ev_cond = 0, ev_taken = 0;
   logic [31:0] ev_pc = 0, ev_target = 0, lk_pc = 0;
   logic ready;
   logic [NTAB-1:0][OW-1:0] lk_idx, lk_tag;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   bit mbuf [DEPTH];
   int mptr = 0;
   int fi [NTAB], f0 [NTAB], f1 [NTAB];

   always #4 clk = ~clk;

   fhist_top #(.NTAB(NTAB), .DEPTH(DEPTH), .PCW(32), .TW(32), .OW(OW),
               .HLEN(HL), .LOGSZ(LS), .TAGW(TG)) dut (
      .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_pc(ev_pc), .ev_target(ev_target),
      .ev_cond(ev_cond), .ev_taken(ev_taken), .ready(ready), .lk_pc(lk_pc),
      .lk_idx(lk_idx), .lk_tag(lk_tag));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int fold_upd(int c, bit nb, bit ob, int w, int l);
      int n;
      n = (c << 1) | int'(nb);
      n = n ^ (int'(ob) << (l % w));
      n = n ^ (n >> w);
      return n & ((1 << w) - 1);
   endfunction

   task automatic model_bit(input bit b);
      mptr = (mptr - 1) & (DEPTH - 1);
      mbuf[mptr] = b;
      for (int t = 0; t < NTAB; t++) begin
         bit ob;
         ob = mbuf[(mptr + HL[t]) & (DEPTH - 1)];
         fi[t] = fold_upd(fi[t], b, ob, LS[t], HL[t]);
         f0[t] = fold_upd(f0[t], b, ob, TG[t], HL[t]);
         f1[t] = fold_upd(f1[t], b, ob, TG[t] - 1, HL[t]);
      end
   endtask

   task automatic model_event(input logic [31:0] pc, input logic [31:0] tg, input bit c, input bit tk);
      logic [31:0] s;
      s = c ? {31'b0, tk} : ((tg ^ (tg >> 3) ^ pc) & 32'h3ff);
      for (int i = 0; i < 10; i++) model_bit(s[i]);
   endtask

   task automatic lookup(input logic [31:0] pc, input string ri, input string rt);
      @(negedge clk);
      lk_pc = pc;
      #1;
      for (int t = 0; t < NTAB; t++) begin
         int sh, ei, et;
         sh = ((LS[t] > t + 1) ? LS[t] - t - 1 : t + 1 - LS[t]) + 1;
         ei = int'((pc ^ (pc >> sh)) & ((32'd1 << LS[t]) - 1)) ^ fi[t];
         et = int'((pc ^ 32'(f0[t]) ^ 32'(f1[t] << 1)) & ((32'd1 << TG[t]) - 1));
         chk(int'(lk_idx[t]) == ei, ri, int'(lk_idx[t]), ei);
         chk(int'(lk_tag[t]) == et, rt, int'(lk_tag[t]), et);
      end
   endtask

   task automatic do_event(input logic [31:0] pc, input logic [31:0] tg, input bit c,
                           input bit tk, input bit noise);
      @(negedge clk);
      chk(ready === 1'b1, "R2", int'(ready), 1);
      ev_valid = 1; ev_pc = pc; ev_target = tg; ev_cond = c; ev_taken = tk;
      @(negedge clk);
      ev_valid = 0;
      chk(ready === 1'b0, "R2", int'(ready), 0);
      for (int i = 1; i < 10; i++) begin
         @(negedge clk);
         if (noise && i < 4) begin
            ev_valid = 1; ev_pc = $urandom; ev_target = $urandom;
            ev_cond = 0; ev_taken = 1;
         end else begin
            ev_valid = 0;
         end
         chk(ready === 1'b0, noise ? "R3" : "R2", int'(ready), 0);
      end
      @(negedge clk);
      ev_valid = 0;
      chk(ready === 1'b1, "R2", int'(ready), 1);
      model_event(pc, tg, c, tk);
   endtask

   initial begin
      void'($urandom(32'h5eed));
      for (int t = 0; t < NTAB; t++) begin fi[t] = 0; f0[t] = 0; f1[t] = 0; end
      for (int i = 0; i < DEPTH; i++) mbuf[i] = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      #1;
      chk(ready === 1'b1, "R1", int'(ready), 1);
      lookup(32'hdeadbeef, "R1", "R1");
      lookup(32'h0000ffff, "R1", "R1");
      do_event(32'h12345678, 32'h0000abcd, 0, 0, 0);
      lookup(32'h12345678, "R4", "R4");
      do_event(32'h00400000, 32'h00400123, 1, 1, 0);
      lookup(32'hcafe0000, "R5", "R5");
      do_event(32'h00400004, 32'h7fffffff, 1, 0, 0);
      lookup(32'h00000001, "R5", "R5");
      do_event(32'h00401000, 32'h00873210, 0, 1, 1);
      lookup(32'h00401000, "R3", "R3");
      for (int e = 0; e < 450; e++) begin
         logic [31:0] pc, tg;
         pc = $urandom; tg = $urandom;
         do_event(pc, tg, ($urandom % 3) == 0, $urandom % 2, ($urandom % 8) == 0);
         if (e % 15 == 0) lookup($urandom, "R8", "R9");
         else if (e % 15 == 7) lookup(pc, "R7", "R7");
      end
      lookup(32'h89abcdef, "R6", "R6");
      lookup(32'h00000000, "R6", "R6");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule